// File: doc/BRIEF.md
# Serial EEPROM status and write-protect controller

This block keeps the status register of a serial EEPROM and rules on every write request that the command decoder raises. It receives already-decoded command strobes (set write-enable, clear write-enable, write status, write memory), the array address of a memory write, the data byte of a status write, the active-low write-protect pin and the busy flag of the internal program timer. For each status or memory write request it answers in the same cycle with either a grant or a deny.

The status byte it presents for reads packs the protect-enable bit, the two block-protect bits, the write-enable latch and an active-low ready flag. The three protection bits are non-volatile: at reset they are loaded from `nv_in`, the stored copy, and `nv_out` gives the value to store back whenever a granted status write changes it. The block-protect bits fence off the top quarter, the top half or all of the array. The protect-enable bit together with a low pin locks the status register. The address width is a parameter (11 bits by default). Shifting, opcode decoding, array storage and program-cycle timing belong to neighbouring blocks.

Top module: `eeprom_wprot_ctrl`

## Requirements
- R1: `status_byte` is {wpen, 0, 0, 0, bp1, bp0, wel, ready}. Bit 7 is wpen, bits 6 to 4 read 0, bits 3 and 2 are bp1 and bp0, bit 1 is wel and bit 0 is the ready flag. `nv_out` is {wpen, bp1, bp0}, and reset loads these three bits from `nv_in`.
- R2: Status bit 0 equals `busy`. It is 1 during an internal write cycle and 0 when commands can be accepted. No command writes it.
- R3: The write-enable latch is 0 after reset. A `cmd_wren` pulse sets it to 1 and a `cmd_wrdi` pulse clears it to 0, each visible from the next cycle.
- R4: A granted `cmd_wrsr` loads wpen from data bit 7, bp1 from data bit 3 and bp0 from data bit 2, visible from the next cycle. Data bits 6 to 4, 1 and 0 have no effect.
- R5: The protected zone, with N the array size (2^ADDR_W), is set by {bp1,bp0}. With 00 nothing is protected. With 01 the zone is addresses 3N/4 to N-1 (0x600 to 0x7FF for 11 bits). With 10 it is N/2 to N-1 (0x400 to 0x7FF). With 11 it is the whole array.
- R6: A `cmd_write` to an address inside the protected zone is always denied, whatever the state of wel, wpen and the pin.
- R7: While wel is 0, every status write and every memory write is denied.
- R8: While wel is 1 and `busy` is 0, a memory write outside the zone is granted. A status write is granted unless wpen is 1 and `wp_n` is 0.
- R9: While `busy` is 1, every write request is denied and `cmd_wren`, `cmd_wrdi` and `cmd_wrsr` leave all state unchanged.
- R10: After a granted status or memory write, the next `cycle_done` pulse clears wel. A `cycle_done` with no granted write outstanding leaves wel unchanged.
- R11: In a cycle with a request (`cmd_wrsr` or `cmd_write`), exactly one of `wr_grant` and `wr_deny` is 1. With no request, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| nv_in | input | 3 | Stored {wpen, bp1, bp0} loaded at reset |
| cmd_wren | input | 1 | Set write-enable latch strobe |
| cmd_wrdi | input | 1 | Clear write-enable latch strobe |
| cmd_wrsr | input | 1 | Status write request strobe |
| cmd_write | input | 1 | Memory write request strobe |
| wr_addr | input | ADDR_W | Array address of the memory write |
| wrsr_data | input | 8 | Data byte of the status write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write cycle in progress |
| cycle_done | input | 1 | Pulse when the internal write cycle ends |
| status_byte | output | 8 | Status register for reads |
| wr_grant | output | 1 | Request in this cycle is allowed |
| wr_deny | output | 1 | Request in this cycle is refused |
| nv_out | output | 3 | Current {wpen, bp1, bp0} to store |

## Verification
The bench sweeps every combination of block-protect code, protect-enable, pin level, write-enable latch and busy flag. Under each combination it probes both sides of every zone boundary and a spread of addresses across the array, with memory writes and with status writes. This separates a wrong zone edge from a wrong permission rule, and it separates the status-register lock from the memory fence. Directed sequences then cover the field masking of the status write, the clearing of the latch on cycle completion with and without an outstanding grant, and commands that arrive while busy and must change nothing.

// File: rtl/ewp_pkg.sv
package ewp_pkg;
  localparam int STAT_W = 8;
  localparam int POS_WPEN = 7;
  localparam int POS_BP1 = 3;
  localparam int POS_BP0 = 2;
  localparam int POS_WEL = 1;
  localparam int POS_RDY = 0;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nv_bits_t;

  function automatic nv_bits_t pick_nv(input logic [STAT_W-1:0] d);
    nv_bits_t r;
    r.wpen = d[POS_WPEN];
    r.bp   = {d[POS_BP1], d[POS_BP0]};
    return r;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input nv_bits_t nv,
                                                    input logic wel,
                                                    input logic rdy);
    logic [STAT_W-1:0] s;
    s = '0;
    s[POS_WPEN] = nv.wpen;
    s[POS_BP1]  = nv.bp[1];
    s[POS_BP0]  = nv.bp[0];
    s[POS_WEL]  = wel;
    s[POS_RDY]  = rdy;
    return s;
  endfunction
endpackage

// File: rtl/ewp_zone_decode.sv
module ewp_zone_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              in_zone
);
  localparam int TOP = ADDR_W - 1;

  function automatic logic zone_hit(input logic [ADDR_W-1:0] a, input logic [1:0] code);
    logic hit;
    case (code)
      2'b00:   hit = 1'b0;
      2'b01:   hit = a[TOP] & a[TOP-1];
      2'b10:   hit = a[TOP];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

  assign in_zone = zone_hit(addr, bp);
endmodule

// File: rtl/ewp_permit.sv
module ewp_permit (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wrsr,
  input  logic cmd_write,
  input  logic in_zone,
  input  logic wel,
  input  logic wpen,
  input  logic wp_n,
  input  logic busy,
  output logic sr_grant,
  output logic mem_grant
);
  logic hw_lock;
  logic open_gate;

  assign hw_lock   = wpen & ~wp_n;
  assign open_gate = wel & ~busy;
  assign sr_grant  = cmd_wrsr & open_gate & ~hw_lock;
  assign mem_grant = cmd_write & open_gate & ~in_zone;

  AST_ZONE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && in_zone) |-> !mem_grant); // R6
  AST_NO_WEL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel) |-> !(sr_grant || mem_grant)); // R7
  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && wpen && !wp_n) |-> !sr_grant); // R8
  AST_BUSY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(sr_grant || mem_grant)); // R9
endmodule

// File: rtl/ewp_status_reg.sv
module ewp_status_reg
  import ewp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  nv_bits_t          nv_in,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              sr_grant,
  input  logic              mem_grant,
  input  logic [STAT_W-1:0] wrsr_data,
  input  logic              busy,
  input  logic              cycle_done,
  output logic              wel,
  output nv_bits_t          nv_q
);
  logic pending;
  logic done_clear;
  logic set_req;
  logic clr_req;

  assign done_clear = cycle_done & pending;
  assign set_req    = cmd_wren & ~busy;
  assign clr_req    = cmd_wrdi & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      pending <= 1'b0;
      nv_q    <= nv_in;
    end else begin
      if (sr_grant) nv_q <= pick_nv(wrsr_data);
      if (sr_grant || mem_grant) pending <= 1'b1;
      else if (cycle_done)       pending <= 1'b0;
      if (done_clear)   wel <= 1'b0;
      else if (set_req) wel <= 1'b1;
      else if (clr_req) wel <= 1'b0;
    end
  end

  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !done_clear) |=> wel); // R3
  AST_WEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !wel); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(nv_q)); // R9
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done_clear |=> !wel); // R10
endmodule

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl
  import ewp_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        nv_in,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STAT_W-1:0] wrsr_data,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              cycle_done,
  output logic [STAT_W-1:0] status_byte,
  output logic              wr_grant,
  output logic              wr_deny,
  output logic [2:0]        nv_out
);
  logic     in_zone;
  logic     sr_grant;
  logic     mem_grant;
  logic     wel;
  nv_bits_t nv_q;
  logic     any_req;

  ewp_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
    .addr    (wr_addr),
    .bp      (nv_q.bp),
    .in_zone (in_zone)
  );

  ewp_permit u_permit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wrsr  (cmd_wrsr),
    .cmd_write (cmd_write),
    .in_zone   (in_zone),
    .wel       (wel),
    .wpen      (nv_q.wpen),
    .wp_n      (wp_n),
    .busy      (busy),
    .sr_grant  (sr_grant),
    .mem_grant (mem_grant)
  );

  ewp_status_reg u_sreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_in      (nv_bits_t'(nv_in)),
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .sr_grant   (sr_grant),
    .mem_grant  (mem_grant),
    .wrsr_data  (wrsr_data),
    .busy       (busy),
    .cycle_done (cycle_done),
    .wel        (wel),
    .nv_q       (nv_q)
  );

  assign any_req     = cmd_wrsr | cmd_write;
  assign wr_grant    = sr_grant | mem_grant;
  assign wr_deny     = any_req & ~wr_grant;
  assign status_byte = pack_status(nv_q, wel, busy);
  assign nv_out      = nv_q;

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_deny)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wrsr || cmd_write) |-> !(wr_grant || wr_deny)); // R11
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000); // R1
  AST_READY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] == busy); // R2
endmodule

// File: tb/eeprom_wprot_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_wprot_ctrl_bench;
  localparam int AW = 11;
  localparam int N = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] nv_in = 3'b101;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wrsr_data = '0;
  logic wp_n = 1'b1, busy = 1'b0, cycle_done = 1'b0;
  logic [7:0] status_byte;
  logic wr_grant, wr_deny;
  logic [2:0] nv_out;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eeprom_wprot_ctrl #(.ADDR_W(AW)) u_eeprom_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .nv_in(nv_in),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_write(cmd_write), .wr_addr(wr_addr), .wrsr_data(wrsr_data),
    .wp_n(wp_n), .busy(busy), .cycle_done(cycle_done),
    .status_byte(status_byte), .wr_grant(wr_grant), .wr_deny(wr_deny),
    .nv_out(nv_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int zone_base(input int bp);
    case (bp)
      1: return N - N / 4;
      2: return N - N / 2;
      3: return 0;
      default: return N;
    endcase
  endfunction

  function automatic int exp_st(input int wpen, input int bp, input int wel, input int bsy);
    return wpen * 128 + bp * 4 + wel * 2 + bsy;
  endfunction

  task automatic pulse_wren();
    @(negedge clk); cmd_wren = 1; @(negedge clk); cmd_wren = 0;
  endtask
  task automatic pulse_wrdi();
    @(negedge clk); cmd_wrdi = 1; @(negedge clk); cmd_wrdi = 0;
  endtask
  task automatic pulse_wrsr(input logic [7:0] d);
    @(negedge clk); cmd_wrsr = 1; wrsr_data = d; @(negedge clk); cmd_wrsr = 0;
  endtask
  task automatic pulse_done();
    @(negedge clk); cycle_done = 1; @(negedge clk); cycle_done = 0;
  endtask

  task automatic probe_mem(input int a, input int exp_g, input int req_is_r6);
    @(negedge clk);
    wr_addr = AW'(a); cmd_write = 1;
    #1;
    if (req_is_r6 != 0) check("R6 zone deny", int'(wr_grant), exp_g);
    else check("R8 memory grant", int'(wr_grant), exp_g);
    check("R11 deny complement", int'(wr_deny), 1 - exp_g);
    cmd_write = 0;
  endtask

  task automatic probe_sr(input int exp_g);
    @(negedge clk);
    wrsr_data = 8'h00; cmd_wrsr = 1;
    #1;
    check("R8 status grant", int'(wr_grant), exp_g);
    check("R11 deny complement", int'(wr_deny), 1 - exp_g);
    cmd_wrsr = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset loads nv_in = {wpen=1, bp=01}
    check("R1 reset status", int'(status_byte), 8'h84);
    check("R1 reset nv_out", int'(nv_out), 3'b101);
    check("R3 reset wel", int'(status_byte[1]), 0);
    #1;
    check("R11 idle quiet", int'({wr_grant, wr_deny}), 0);

    // R7 with wel 0 everything denied
    probe_sr(0);
    probe_mem(0, 0, 0);

    // R3 set/clear
    pulse_wren();
    check("R3 wren sets wel", int'(status_byte[1]), 1);
    pulse_wrdi();
    check("R3 wrdi clears wel", int'(status_byte[1]), 0);

    // R4 masking: data 0x73 -> only bits 7,3,2 matter (all 0 here)
    pulse_wren();
    pulse_wrsr(8'h73);
    check("R4 masked status write", int'(status_byte), 8'h02);
    pulse_done();
    check("R10 done clears wel", int'(status_byte[1]), 0);
    pulse_wren();
    pulse_wrsr(8'h8C);
    check("R4 status write fields", int'(status_byte), 8'h8E);
    check("R4 nv_out", int'(nv_out), 3'b111);
    pulse_done();
    check("R10 done clears wel after wrsr", int'(status_byte), 8'h8C);

    // R10 done without outstanding grant keeps wel
    pulse_wren();
    pulse_done();
    check("R10 idle done keeps wel", int'(status_byte[1]), 1);

    // R8 lock: wpen=1, pin low blocks status write, state kept
    @(negedge clk); wp_n = 0;
    pulse_wrsr(8'h00);
    check("R8 locked status unchanged", int'(status_byte), 8'h8E);
    @(negedge clk); wp_n = 1;

    // R9 busy: commands ignored
    pulse_wrdi();
    @(negedge clk); busy = 1;
    #1;
    check("R2 ready flag busy", int'(status_byte[0]), 1);
    pulse_wren();
    check("R9 busy wren ignored", int'(status_byte[1]), 0);
    @(negedge clk); busy = 0;
    pulse_wren();
    @(negedge clk); busy = 1;
    pulse_wrdi();
    check("R9 busy wrdi ignored", int'(status_byte[1]), 1);
    pulse_wrsr(8'h00);
    check("R9 busy wrsr ignored", int'(nv_out), 3'b111);
    @(negedge clk); busy = 0;
    #1;
    check("R2 ready flag idle", int'(status_byte[0]), 0);
    pulse_done();

    // Exhaustive sweep: bp, wpen, pin, wel, busy
    for (int bp = 0; bp < 4; bp++)
      for (int wpen = 0; wpen < 2; wpen++)
        for (int pin = 0; pin < 2; pin++)
          for (int wel = 0; wel < 2; wel++)
            for (int bsy = 0; bsy < 2; bsy++) begin
              @(negedge clk); wp_n = 1; busy = 0;
              pulse_wren();
              pulse_wrsr(8'(wpen * 128 + bp * 4));
              pulse_done();
              if (wel != 0) pulse_wren();
              @(negedge clk); wp_n = pin[0]; busy = bsy[0];
              #1;
              // R5 and R1 status content
              check("R1 sweep status", int'(status_byte), exp_st(wpen, bp, wel, bsy));
              for (int k = 0; k < 40; k++) begin
                int a;
                int inz;
                int g;
                if (k < 32) a = k * (N / 32) + (k % 7);
                else case (k)
                  32: a = N / 2 - 1;
                  33: a = N / 2;
                  34: a = N - N / 4 - 1;
                  35: a = N - N / 4;
                  36: a = N - 1;
                  37: a = 0;
                  38: a = N / 4;
                  default: a = N - N / 8;
                endcase
                inz = (a >= zone_base(bp)) ? 1 : 0;
                g = (wel == 1 && bsy == 0 && inz == 0) ? 1 : 0;
                probe_mem(a, g, inz); // R5 boundaries via zone_base
              end
              probe_sr((wel == 1 && bsy == 0 && !(wpen == 1 && pin == 0)) ? 1 : 0);
              @(negedge clk); busy = 0;
              pulse_done();
            end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule